// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block lets a clocked host read and write single bytes in an external asynchronous 512K x 8 static RAM. The host offers one request at a time: a direction bit, a 19-bit word address and, for writes, a data byte. The sequencer turns each request into registered, active-low chip-select, write-enable and output-enable strobes, and it drives the RAM's shared 8-bit data bus only while a write is in progress.

Every analog timing figure of the memory becomes a whole number of controller clock cycles through parameters. The write pulse, data setup before the end of the write, write recovery, total write cycle, read access time, bus turnaround and power-up settling are all rounded up in that way. Chip select stays low from one read into the next, so a new read starts on the address change alone. A write that follows a read first waits with output enable high until the memory has released the bus. Completion is signalled by a one-cycle `done` pulse. For reads, `rdata` holds the byte sampled on the last cycle of the access window.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset is released, `ready` stays low and chip select and write enable stay high for exactly SETTLE_CYC cycles. `ready` is first high SETTLE_CYC cycles after the release.
- R2: While reset is asserted, all three strobes are high, `ready` and `done` are low and the data bus is released (high impedance).
- R3: A read holds chip select and output enable low and write enable high. `done` rises exactly RD_ACC_CYC cycles after the accepting clock edge, with `rdata` equal to the byte stored at the requested address.
- R4: Between two reads chip select stays low. After a write, chip select is high while the sequencer is idle.
- R5: Write enable stays low for exactly 1 + WDRV cycles, where WDRV = max(DSETUP_CYC, WR_PULSE_CYC - 1), and the memory address does not change while it is low.
- R6: The data bus is driven only while write enable is low, never in the first low cycle, for exactly WDRV cycles ending on the last low cycle. It is released in the cycle write enable rises.
- R7: After a write pulse, write enable stays high for at least WREC = max(WR_RECOV_CYC, WR_CYCLE_CYC - 1 - WDRV) cycles. `done` follows a write exactly 1 + WDRV + WREC cycles after acceptance, plus TURN_CYC when the previous access was a read.
- R8: When a write follows a read, at least TURN_CYC + 1 cycles with the memory output disabled pass before the sequencer drives data.
- R9: A request is taken only in a cycle with `ready` high. A request raised while busy has no effect on memory contents. `done` is high for one cycle at a time.
- R10: The memory output (chip select low, output enable low, write enable high) and the sequencer's data driver are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address of the request |
| wdata | input | 8 | Byte to write |
| ready | output | 1 | Sequencer idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| sram_addr | output | 19 | Registered memory address |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq | inout | 8 | Bidirectional memory data bus |

## Verification
Assertions check, on every cycle, that nothing is strobed during the settling lockout and that the data driver is active only with write enable low and output enable high. They also check that the address stays still across a write pulse, that every rising write enable was preceded by driven data, that a turnaround precedes the first drive, and that `done` lasts one cycle. Whether bytes actually land in and return from the memory, the exact pulse lengths, recovery gaps and completion latencies, the chip-select behaviour between reads, and the harmlessness of a request raised while busy can only be shown by the bench's scenarios against its behavioural memory model.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WOFF,
        ST_WDRV,
        ST_WREC
    } ctl_state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } host_req_t;

    localparam strobe_t STB_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int maxi(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int SETTLE_CYC   = 25000,
    parameter int RD_ACC_CYC   = 5,
    parameter int WR_PULSE_CYC = 2,
    parameter int DSETUP_CYC   = 1,
    parameter int WR_RECOV_CYC = 1,
    parameter int WR_CYCLE_CYC = 3,
    parameter int TURN_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  host_req_t         hreq,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output strobe_t           stb,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);

    localparam int WDRV = maxi(DSETUP_CYC, WR_PULSE_CYC - 1);
    localparam int WREC = maxi(WR_RECOV_CYC, WR_CYCLE_CYC - 1 - WDRV);
    localparam int TMAX = maxi(maxi(SETTLE_CYC, RD_ACC_CYC), maxi(maxi(WDRV, WREC), TURN_CYC));
    localparam int TW   = $clog2(TMAX + 1) + 1;

    ctl_state_t st, nxt;
    logic       tz;
    logic       tload;
    logic [TW-1:0] tval;
    logic       last_rd;

    function automatic int state_len(input ctl_state_t s);
        case (s)
            ST_RD:   return RD_ACC_CYC;
            ST_TURN: return TURN_CYC;
            ST_WDRV: return WDRV;
            ST_WREC: return WREC;
            default: return 1;
        endcase
    endfunction

    always_comb begin
        nxt = st;
        case (st)
            ST_SETTLE: if (tz) nxt = ST_IDLE;
            ST_IDLE:   if (req) nxt = hreq.wr ? (last_rd ? ST_TURN : ST_WOFF) : ST_RD;
            ST_RD:     if (tz) nxt = ST_IDLE;
            ST_TURN:   if (tz) nxt = ST_WOFF;
            ST_WOFF:   if (tz) nxt = ST_WDRV;
            ST_WDRV:   if (tz) nxt = ST_WREC;
            ST_WREC:   if (tz) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        tload = (nxt != st);
        tval  = TW'(state_len(nxt) - 1);
    end

    sramc_timer #(
        .W       (TW),
        .RST_VAL (TW'(SETTLE_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .zero     (tz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_SETTLE;
            stb      <= STB_OFF;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
            mem_addr <= '0;
            rdata    <= '0;
            done     <= 1'b0;
            last_rd  <= 1'b0;
        end else begin
            st   <= nxt;
            done <= 1'b0;
            if (st == ST_IDLE && req) begin
                mem_addr <= hreq.a;
                dq_out   <= hreq.d;
            end
            case (nxt)
                ST_RD:   stb <= '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0};
                ST_TURN: stb <= '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1};
                ST_WOFF: begin
                    stb     <= '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1};
                    last_rd <= 1'b0;
                end
                ST_WDRV: dq_oe <= 1'b1;
                ST_WREC: begin
                    stb.we_n <= 1'b1;
                    dq_oe    <= 1'b0;
                end
                default: ;
            endcase
            if (st == ST_RD && tz) begin
                rdata   <= dq_in;
                done    <= 1'b1;
                last_rd <= 1'b1;
            end
            if (st == ST_WREC && tz) begin
                stb.cs_n <= 1'b1;
                done     <= 1'b1;
            end
        end
    end

    assign ready = (st == ST_IDLE);

    AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE) |-> (stb.cs_n && stb.we_n && !ready)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_TAKE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!stb.we_n && $past(!stb.we_n)) |-> $stable(mem_addr)); // R5
    AST_RISE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        $rose(stb.we_n) |-> $past(dq_oe)); // R6
    AST_TURN_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> ($past(stb.oe_n) && $past(!stb.we_n))); // R8

endmodule

// File: rtl/sramc_iobuf.sv
module sramc_iobuf #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] pad,
    input  logic         en,
    input  logic [W-1:0] d_out,
    output logic [W-1:0] d_in
);

    assign pad  = en ? d_out : {W{1'bz}};
    assign d_in = pad;

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int SETTLE_CYC   = 25000,
    parameter int RD_ACC_CYC   = 5,
    parameter int WR_PULSE_CYC = 2,
    parameter int DSETUP_CYC   = 1,
    parameter int WR_RECOV_CYC = 1,
    parameter int WR_CYCLE_CYC = 3,
    parameter int TURN_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);

    host_req_t         hreq;
    strobe_t           stb;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in;

    assign hreq = '{wr: we, a: addr, d: wdata};

    sramc_seq #(
        .SETTLE_CYC   (SETTLE_CYC),
        .RD_ACC_CYC   (RD_ACC_CYC),
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .DSETUP_CYC   (DSETUP_CYC),
        .WR_RECOV_CYC (WR_RECOV_CYC),
        .WR_CYCLE_CYC (WR_CYCLE_CYC),
        .TURN_CYC     (TURN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .hreq     (hreq),
        .dq_in    (dq_in),
        .ready    (ready),
        .done     (done),
        .rdata    (rdata),
        .mem_addr (sram_addr),
        .stb      (stb),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out)
    );

    sramc_iobuf #(.W(DATA_W)) u_io (
        .pad   (sram_dq),
        .en    (dq_oe),
        .d_out (dq_out),
        .d_in  (dq_in)
    );

    assign sram_cs_n = stb.cs_n;
    assign sram_we_n = stb.we_n;
    assign sram_oe_n = stb.oe_n;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!sram_we_n && sram_oe_n && !sram_cs_n)); // R10

endmodule

// File: tb/sramc_ctrl_test.sv
module sramc_ctrl_test;

    localparam int SETTLE = 20;
    localparam int RDACC  = 4;
    localparam int WPULSE = 3;
    localparam int DSET   = 1;
    localparam int RECOV  = 1;
    localparam int WCYC   = 5;
    localparam int TURN   = 2;
    localparam int DRV    = (DSET > WPULSE - 1) ? DSET : WPULSE - 1;
    localparam int REC    = (RECOV > WCYC - 1 - DRV) ? RECOV : WCYC - 1 - DRV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, done;
    logic [7:0]  rdata;
    logic [18:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    wire  [7:0]  sram_dq;

    sramc_ctrl #(
        .SETTLE_CYC (SETTLE), .RD_ACC_CYC (RDACC), .WR_PULSE_CYC (WPULSE),
        .DSETUP_CYC (DSET), .WR_RECOV_CYC (RECOV), .WR_CYCLE_CYC (WCYC),
        .TURN_CYC (TURN)
    ) uut (
        .clk (clk), .rst (rst), .req (req), .we (we), .addr (addr),
        .wdata (wdata), .ready (ready), .done (done), .rdata (rdata),
        .sram_addr (sram_addr), .sram_cs_n (sram_cs_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .sram_dq (sram_dq)
    );

    always #2 clk = ~clk;

    logic [7:0] mem  [1024];
    logic [7:0] expm [1024];
    wire        mdrive = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq = mdrive ? mem[sram_addr[9:0]] : 8'hzz;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural memory and timing monitor
    logic        prev_we_n = 1'b1;
    int          we_run = 0, drv_run = 0, hi_run = 1000, since_md = 1000;
    logic [18:0] a_first;
    logic [9:0]  cap_a;
    logic [7:0]  cap_d;
    logic        last_drv = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit ctrl_drv = !mdrive && (sram_dq !== 8'hzz);
            if (mdrive) begin
                since_md = 0;
                chk(!$isunknown(sram_dq), "R10 bus contention", 0, 0);
            end else if (since_md < 1000) begin
                since_md++;
            end
            if (ctrl_drv) begin
                chk(sram_we_n == 1'b0, "R6 drive with we high", sram_we_n, 0);
                if (drv_run == 0)
                    chk(since_md >= TURN + 2, "R8 turnaround", since_md, TURN + 2);
            end
            if (!sram_we_n) begin
                if (prev_we_n) begin
                    chk(hi_run >= REC, "R7 recovery gap", hi_run, REC);
                    we_run  = 1;
                    drv_run = 0;
                    a_first = sram_addr;
                    chk(!ctrl_drv, "R6 drive in first low cycle", ctrl_drv, 0);
                end else begin
                    we_run++;
                    chk(sram_addr == a_first, "R5 address moved", sram_addr, a_first);
                end
                if (ctrl_drv) begin
                    drv_run++;
                    cap_a = sram_addr[9:0];
                    cap_d = sram_dq;
                end
                last_drv = ctrl_drv;
            end else if (!prev_we_n) begin
                chk(we_run == 1 + DRV, "R5 pulse length", we_run, 1 + DRV);
                chk(drv_run == DRV, "R6 drive length", drv_run, DRV);
                chk(last_drv, "R6 data at end of pulse", last_drv, 1);
                chk(!ctrl_drv, "R6 released at rise", ctrl_drv, 0);
                mem[cap_a] = cap_d;
                hi_run = 1;
            end else if (hi_run < 1000) begin
                hi_run++;
            end
            prev_we_n = sram_we_n;
        end
    end

    bit last_was_rd = 1'b0;

    task automatic do_op(input bit w, input logic [18:0] a, input logic [7:0] d);
        int n;
        int exp_lat;
        while (!ready) @(negedge clk);
        if (last_was_rd) chk(sram_cs_n == 1'b0, "R4 cs held low between reads", sram_cs_n, 0);
        else             chk(sram_cs_n == 1'b1, "R4 cs high after write", sram_cs_n, 1);
        exp_lat = w ? ((last_was_rd ? TURN : 0) + 1 + DRV + REC) : RDACC;
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 100);
        if (w) begin
            chk(n == exp_lat, "R7 write latency", n, exp_lat);
            expm[a[9:0]] = d;
        end else begin
            chk(n == exp_lat, "R3 read latency", n, exp_lat);
            chk(rdata == expm[a[9:0]], "R3 read data", rdata, expm[a[9:0]]);
        end
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        last_was_rd = !w;
    endtask

    function automatic logic [18:0] mk(input int k);
        return {9'(k * 37), 10'(k)};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'h00;
            expm[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk(sram_cs_n && sram_we_n && sram_oe_n, "R2 strobes in reset",
            {sram_cs_n, sram_we_n, sram_oe_n}, 7);
        chk(!ready && !done, "R2 ready/done in reset", {ready, done}, 0);
        chk(sram_dq === 8'hzz, "R2 bus released in reset", sram_dq, 0);

        // R1 settling lockout
        begin
            int n = 0;
            bit quiet = 1'b1;
            rst = 1'b0;
            while (!ready && n < 1000) begin
                @(negedge clk);
                n++;
                if (!ready && !(sram_cs_n && sram_we_n)) quiet = 1'b0;
            end
            chk(n == SETTLE, "R1 settle length", n, SETTLE);
            chk(quiet, "R1 strobes quiet while settling", quiet, 1);
        end

        // write sweep, then read sweep (back-to-back reads)
        for (int k = 0; k < 64; k++) do_op(1'b1, mk(k), 8'((k * 29 + 7) ^ 8'h5A));
        for (int k = 0; k < 64; k++) do_op(1'b0, mk(k), 8'h00);
        // alternating write-after-read for turnaround
        for (int k = 64; k < 96; k++) begin
            do_op(1'b1, mk(k), 8'(k * 3 + 1));
            do_op(1'b0, mk(k), 8'h00);
        end
        // boundary addresses and data
        do_op(1'b1, 19'h7FFFF, 8'hFF);
        do_op(1'b1, 19'h00000, 8'h00);
        do_op(1'b0, 19'h7FFFF, 8'h00);
        do_op(1'b0, 19'h00000, 8'h00);
        do_op(1'b1, mk(7), 8'hA5);
        do_op(1'b0, mk(7), 8'h00);

        // R9: request raised while busy must not write
        while (!ready) @(negedge clk);
        req = 1'b1; we = 1'b0; addr = mk(5);
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(!ready, "R9 busy during read", ready, 0);
        req = 1'b1; we = 1'b1; addr = mk(5); wdata = ~expm[5];
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        last_was_rd = 1'b1;
        do_op(1'b0, mk(5), 8'h00);
        chk(mem[5] == expm[5], "R9 ignored request left memory", mem[5], expm[5]);

        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule